// File: doc/BRIEF.md
# Dual-Path Digital Offset Adder

This block sits in front of a converter and adds a programmable signed offset to each of two 12-bit two's-complement sample streams, A and B. Each path has a 13-bit signed offset word. The word holds four fractional bits, so the offset actually added is the word divided by 16. That gives an adjustment of -256 to +255 LSB. The sum is limited to the signed 12-bit range and registered once, so outputs and their valid flag follow the inputs by one clock.

Offset words arrive over a simple write port: one strobe, a path select and a 13-bit value. Each path keeps a shadow copy, which receives writes, and an active copy, which feeds the adder. A mode input chooses how the active copy is updated. With the mode low, writes reach the adder at once. With the mode high, writes stay in the shadow until a sync pulse arrives.

A two-state update controller decides when shadow words move to the active copies:
- In `ST_CLEAN`, shadow and active copies agree. A write while the mode is high takes the transition `CLEAN_TO_PENDING`.
- In `ST_PENDING`, new words wait in the shadow. A sync pulse with no write in the same cycle takes `PENDING_TO_CLEAN_SYNC`. A sync pulse that coincides with a write stays in `ST_PENDING` through `PENDING_RESYNC`. Dropping the mode takes `PENDING_TO_CLEAN_RELEASE`.

Top module: `dual_offset_adder`

## Requirements
- R1: After reset, `out_valid` and both outputs are 0, and both shadow and active offsets are 0, so a sample passes through unchanged.
- R2: The offset added is the 13-bit signed word shifted right arithmetically by 4 (rounding toward negative infinity). For example, word -1 gives -1 and word 15 gives 0.
- R3: When no limiting occurs, the output equals the input sample plus the scaled offset, with both aligned at bit 0.
- R4: A sum above 2047 gives an output of 2047 (0x7FF).
- R5: A sum below -2048 gives an output of -2048 (0x800).
- R6: `out_valid` and the outputs update one clock after the input is presented.
- R7: `wr_sel` = 0 writes path A and `wr_sel` = 1 writes path B. A write to one path leaves the other path's offset unchanged.
- R8: With `sync_mode` = 0, a word written at a clock edge applies to samples captured at the next edge.
- R9: With `sync_mode` = 1, a written word does not change the outputs until a sync pulse.
- R10: With `sync_mode` = 1, a `sync_pulse` moves both shadow words into the active copies. A word written in the same cycle as the pulse stays pending, and the older shadow word is the one applied.
- R11: Lowering `sync_mode` while a word is pending applies it at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Offset write strobe |
| wr_sel | input | 1 | Path select for the write: 0 = A, 1 = B |
| wr_data | input | 13 | Signed offset word, 4 fractional bits |
| sync_mode | input | 1 | 1 = hold writes until a sync pulse |
| sync_pulse | input | 1 | Single-cycle sync event |
| in_valid | input | 1 | Input sample qualifier |
| in_a | input | 12 | Path A sample, signed |
| in_b | input | 12 | Path B sample, signed |
| out_valid | output | 1 | Output qualifier |
| out_a | output | 12 | Path A result, signed |
| out_b | output | 12 | Path B result, signed |

## Verification
The assertions assume three things about the inputs:
- `sync_pulse` is a one-cycle event.
- `sync_mode` is steady across a write and the sync pulse that follows it.
- Samples are plain two's-complement words.

They also rely on shadow and active copies being equal whenever the controller is clean. The stimulus changes the mode only at idle points, drives every strobe for exactly one clock, and sweeps offset words across the full 13-bit range against samples at both extremes and around zero.

// File: rtl/offs_pkg.sv
package offs_pkg;
    typedef enum logic {
        ST_CLEAN   = 1'b0,
        ST_PENDING = 1'b1
    } upd_state_t;

    typedef enum logic [1:0] {
        SRC_HOLD   = 2'd0,
        SRC_NEXT   = 2'd1,
        SRC_SHADOW = 2'd2
    } act_src_t;
endpackage

// File: rtl/offs_update_ctrl.sv
module offs_update_ctrl
    import offs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       sync_mode,
    input  logic       sync_pulse,
    output act_src_t   act_src,
    output upd_state_t state
);
    upd_state_t state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_CLEAN;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        act_src   = SRC_HOLD;
        unique case (state)
            ST_CLEAN: begin
                if (!sync_mode) begin
                    act_src = SRC_NEXT;
                end else if (wr_en) begin
                    state_nxt = ST_PENDING;              // CLEAN_TO_PENDING
                end
            end
            ST_PENDING: begin
                if (!sync_mode) begin
                    act_src   = SRC_NEXT;
                    state_nxt = ST_CLEAN;                // PENDING_TO_CLEAN_RELEASE
                end else if (sync_pulse) begin
                    act_src   = SRC_SHADOW;
                    state_nxt = wr_en ? ST_PENDING       // PENDING_RESYNC
                                      : ST_CLEAN;        // PENDING_TO_CLEAN_SYNC
                end
            end
            default: state_nxt = ST_CLEAN;
        endcase
    end
endmodule

// File: rtl/offs_regs.sv
module offs_regs
    import offs_pkg::*;
#(
    parameter int OFS_W   = 13,
    parameter int N_PATHS = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    wr_sel,
    input  logic signed [OFS_W-1:0] wr_data,
    input  act_src_t                act_src,
    output logic signed [OFS_W-1:0] shd [N_PATHS],
    output logic signed [OFS_W-1:0] act [N_PATHS]
);
    for (genvar p = 0; p < N_PATHS; p++) begin : g_path
        logic signed [OFS_W-1:0] shd_nxt;

        always_comb begin
            shd_nxt = shd[p];
            if (wr_en && (wr_sel == 1'(p))) shd_nxt = wr_data;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                shd[p] <= '0;
                act[p] <= '0;
            end else begin
                shd[p] <= shd_nxt;
                unique case (act_src)
                    SRC_NEXT:   act[p] <= shd_nxt;
                    SRC_SHADOW: act[p] <= shd[p];
                    default:    act[p] <= act[p];
                endcase
            end
        end
    end
endmodule

// File: rtl/offs_path.sv
module offs_path #(
    parameter int DATA_W = 12,
    parameter int OFS_W  = 13,
    parameter int FRAC_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [DATA_W-1:0] sample,
    input  logic signed [OFS_W-1:0]  ofs,
    output logic signed [DATA_W-1:0] result
);
    localparam int SCL_W = OFS_W - FRAC_W;
    localparam int SUM_W = ((DATA_W > SCL_W) ? DATA_W : SCL_W) + 1;
    localparam logic signed [SUM_W-1:0] MAX_S = SUM_W'((2 ** (DATA_W - 1)) - 1);
    localparam logic signed [SUM_W-1:0] MIN_S = -MAX_S - SUM_W'(1);

    logic signed [OFS_W-1:0]  ofs_shift;
    logic signed [SCL_W-1:0]  scaled;
    logic signed [SUM_W-1:0]  sum;
    logic signed [DATA_W-1:0] limited;

    always_comb begin
        ofs_shift = ofs >>> FRAC_W;
        scaled    = ofs_shift[SCL_W-1:0];
        sum       = SUM_W'(sample) + SUM_W'(scaled);
        if (sum > MAX_S)      limited = MAX_S[DATA_W-1:0];
        else if (sum < MIN_S) limited = MIN_S[DATA_W-1:0];
        else                  limited = sum[DATA_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) result <= '0;
        else        result <= limited;
    end
endmodule

// File: rtl/dual_offset_adder.sv
module dual_offset_adder
    import offs_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int OFS_W  = 13,
    parameter int FRAC_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     wr_sel,
    input  logic signed [OFS_W-1:0]  wr_data,
    input  logic                     sync_mode,
    input  logic                     sync_pulse,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_a,
    input  logic signed [DATA_W-1:0] in_b,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_a,
    output logic signed [DATA_W-1:0] out_b
);
    localparam int N_PATHS = 2;

    act_src_t                act_src;
    upd_state_t              upd_state;
    logic signed [OFS_W-1:0] shd [N_PATHS];
    logic signed [OFS_W-1:0] act [N_PATHS];
    logic signed [DATA_W-1:0] smp [N_PATHS];
    logic signed [DATA_W-1:0] res [N_PATHS];
    logic signed [OFS_W-1:0] shd_a, shd_b, act_a, act_b;

    assign smp[0] = in_a;
    assign smp[1] = in_b;
    assign out_a  = res[0];
    assign out_b  = res[1];
    assign shd_a  = shd[0];
    assign shd_b  = shd[1];
    assign act_a  = act[0];
    assign act_b  = act[1];

    offs_update_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .sync_mode  (sync_mode),
        .sync_pulse (sync_pulse),
        .act_src    (act_src),
        .state      (upd_state)
    );

    offs_regs #(.OFS_W(OFS_W), .N_PATHS(N_PATHS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .act_src (act_src),
        .shd     (shd),
        .act     (act)
    );

    for (genvar p = 0; p < N_PATHS; p++) begin : g_dp
        offs_path #(.DATA_W(DATA_W), .OFS_W(OFS_W), .FRAC_W(FRAC_W)) u_path (
            .clk    (clk),
            .rst_n  (rst_n),
            .sample (smp[p]),
            .ofs    (act[p]),
            .result (res[p])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end
endmodule

// File: rtl/offs_checker.sv
module offs_checker
    import offs_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int OFS_W  = 13
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     wr_en,
    input logic                     wr_sel,
    input logic signed [OFS_W-1:0]  wr_data,
    input logic                     sync_mode,
    input logic                     sync_pulse,
    input logic                     in_valid,
    input logic signed [DATA_W-1:0] in_a,
    input logic                     out_valid,
    input logic signed [DATA_W-1:0] out_a,
    input logic signed [OFS_W-1:0]  shd_a,
    input logic signed [OFS_W-1:0]  act_a,
    input logic signed [OFS_W-1:0]  act_b,
    input upd_state_t               upd_state
);
    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);                                          // R6
    AST_VALID_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);                                        // R6
    AST_NO_WRAP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_a[DATA_W-1] && !act_a[OFS_W-1]) |=> !out_a[DATA_W-1]);       // R4
    AST_NO_WRAP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (in_a[DATA_W-1] && act_a[OFS_W-1]) |=> out_a[DATA_W-1]);          // R5
    AST_IMMEDIATE_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_mode && wr_en && !wr_sel) |=> (act_a == $past(wr_data)));  // R8
    AST_OTHER_PATH_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_mode && wr_en && !wr_sel) |=> $stable(act_b));             // R7
    AST_SYNC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_mode && !sync_pulse) |=> $stable(act_a));                   // R9
    AST_SYNC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_mode && sync_pulse) |=> (act_a == $past(shd_a)));           // R10
    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_state == ST_PENDING && !sync_mode) |=> (upd_state == ST_CLEAN)); // R11
endmodule

bind dual_offset_adder offs_checker #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .sync_mode  (sync_mode),
    .sync_pulse (sync_pulse),
    .in_valid   (in_valid),
    .in_a       (in_a),
    .out_valid  (out_valid),
    .out_a      (out_a),
    .shd_a      (shd_a),
    .act_a      (act_a),
    .act_b      (act_b),
    .upd_state  (upd_state)
);

// File: tb/dual_offset_adder_test.sv
module dual_offset_adder_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, wr_sel = 1'b0, sync_mode = 1'b0, sync_pulse = 1'b0, in_valid = 1'b0;
    logic signed [12:0] wr_data = '0;
    logic signed [11:0] in_a = '0, in_b = '0;
    logic out_valid;
    logic signed [11:0] out_a, out_b;
    int n_chk = 0, n_fail = 0;
    int reg_a = 0, reg_b = 0;

    always #10 clk = ~clk;

    dual_offset_adder uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .sync_mode(sync_mode), .sync_pulse(sync_pulse), .in_valid(in_valid),
        .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_a(out_a), .out_b(out_b)
    );

    function automatic int expect_out(int s, int r);
        int v = s + (r >>> 4);
        if (v > 2047)  v = 2047;
        if (v < -2048) v = -2048;
        return v;
    endfunction

    function automatic string tag_for(int s, int r);
        int v = s + (r >>> 4);
        if (v > 2047)  return "R4";
        if (v < -2048) return "R5";
        return "R2/R3";
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(logic sel, int val, logic with_sync = 1'b0);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = 13'(val); sync_pulse = with_sync;
        @(negedge clk);
        wr_en = 1'b0; sync_pulse = 1'b0;
    endtask

    task automatic pulse_sync();
        @(negedge clk);
        sync_pulse = 1'b1;
        @(negedge clk);
        sync_pulse = 1'b0;
    endtask

    task automatic sample(int a, int b, int ea, int eb, string req_a, string req_b);
        @(negedge clk);
        in_valid = 1'b1; in_a = 12'(a); in_b = 12'(b);
        @(negedge clk);
        in_valid = 1'b0;
        check(req_a, int'(out_a), ea);
        check(req_b, int'(out_b), eb);
    endtask

    initial begin
        #3_000_000;
        n_fail++; n_chk++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int smp[7] = '{-2048, -1000, -1, 0, 1, 1000, 2047};
        repeat (2) @(negedge clk);
        check("R1 valid", int'(out_valid), 0);
        check("R1 out_a", int'(out_a), 0);
        check("R1 out_b", int'(out_b), 0);
        rst_n = 1'b1;
        sample(-77, 1234, -77, 1234, "R1", "R1");

        // R6: latency and valid
        @(negedge clk);
        in_valid = 1'b1; in_a = 12'sd5; in_b = 12'sd6;
        check("R6 no early update", int'(out_a), -77);
        @(negedge clk);
        in_valid = 1'b0;
        check("R6 valid high", int'(out_valid), 1);
        check("R6 data", int'(out_a), 5);
        @(negedge clk);
        check("R6 valid low", int'(out_valid), 0);

        // R2 R3 R4 R5 R8 sweep, immediate mode
        for (int r = -4096; r <= 4095; r += 7) begin
            int rr = (r > 4088) ? 4095 : r;
            reg_a = rr; reg_b = -1 - rr;
            wr(1'b0, reg_a);
            wr(1'b1, reg_b);
            foreach (smp[i]) begin
                sample(smp[i], smp[6 - i],
                       expect_out(smp[i], reg_a), expect_out(smp[6 - i], reg_b),
                       tag_for(smp[i], reg_a), tag_for(smp[6 - i], reg_b));
            end
        end

        // R8: write immediately followed by a sample
        wr(1'b0, 32);
        sample(0, 0, 2, expect_out(0, reg_b), "R8", "R7");
        // R7: write path B only, A keeps its word
        wr(1'b1, -48);
        sample(10, 10, 12, 7, "R7 A kept", "R7 B");
        reg_a = 32; reg_b = -48;

        // R9 / R10: sync mode
        sync_mode = 1'b1;
        wr(1'b0, 160);
        wr(1'b1, 320);
        sample(0, 0, 2, -3, "R9 A held", "R9 B held");
        pulse_sync();
        sample(0, 0, 10, 20, "R10 A", "R10 B");
        wr(1'b0, 480);
        wr(1'b0, 640, 1'b1);
        sample(0, 0, 30, 20, "R10 same-cycle old word", "R10 B");
        pulse_sync();
        sample(0, 0, 40, 20, "R10 second sync", "R10 B");
        pulse_sync();
        sample(0, 0, 40, 20, "R10 idle sync", "R10 B");

        // R11: release pending word by leaving sync mode
        wr(1'b1, -160);
        sample(0, 0, 40, 20, "R9", "R9 B pending");
        @(negedge clk);
        sync_mode = 1'b0;
        @(negedge clk);
        sample(0, 0, 40, -10, "R11", "R11 B released");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule